// File: doc/BRIEF.md
# Multicycle Core Control Sequencer

This block is the central control state machine of a 16-bit multicycle RISC core. Each instruction takes several clock cycles. In every cycle the sequencer reads the opcode and extension bit held in the instruction register, the branch-condition flag and the interrupt inputs. From these it drives the select and write-enable lines that steer the shared datapath: memory address source, memory read and write, instruction and immediate register loads, register-file write and its data source, program-counter load and its source, ALU operand selects and ALU operation.

Every instruction begins with a fetch and a decode. When the extension bit is set, an instruction that can use an immediate fetches one more word before it runs. Every instruction ends in a shared interrupt-check state. If the interrupt input is raised and interrupts are enabled, that state starts a two-cycle entry sequence. The sequence saves the PC, disables interrupts and loads the PC with a fixed service-routine address before the next fetch.

Top module: `ctl_sequencer`

## Requirements
- R1: While reset is active, and for one cycle after it is released (reset release passes two synchronizing flops), every output enable is 0 and the state code is 0. The first fetch follows.
- R2: The fetch state (code 0) drives mem_rd=1, ir_wr=1, iord=0, alu_a=2, alu_b=2, alu_op=1 (ADD), pc_sel=0 and pc_wr=1, and always moves to decode (code 1). Decode drives every output at 0. The ALU operation codes are 0 off, 1 ADD, 2 SUB and 3 opcode-defined.
- R3: If ext=1, an ALU, load, store, compare or immediate-jump instruction goes from decode to the immediate-fetch state (code 4). That state drives the fetch outputs, except that imm_wr=1 takes the place of ir_wr. It then dispatches as decode would. Every other class ignores ext.
- R4: An ALU instruction (opcode[6:4]=000) runs in state 2 with alu_a=0, alu_op=3, and alu_b=1 when ext=1 or alu_b=0 when ext=0. It then writes back in state 8 with rf_wr=1 and rf_src=0 (ALU).
- R5: A load (opcode 0010000) forms its address in state 3 (alu_a=1, alu_b=1, ADD). It reads memory in state 9 (iord=1, mem_rd=1) and writes back in state 6 with rf_wr=1 and rf_src=1 (memory).
- R6: A store (opcode 0010001) forms its address in state 3 and then writes memory in state 5 with iord=1 and mem_wr=1. It makes no register write.
- R7: A compare (opcode 0010010) spends one cycle in state 10 with alu_a=0, alu_b=0, alu_op=2 (SUB) and no write enable.
- R8: A branch (opcode[6:4]=111) spends one cycle in state 11 with alu_a=2, alu_b=3, ADD, pc_cond=1 and pc_wr=1, whatever br_taken is.
- R9: Jump to register (opcode 0010100) spends one cycle in state 12 with pc_sel=1 and pc_wr=1. Jump-and-link to register (0010101) first spends one cycle in state 13 with rf_wr=1, rf_src=2 (PC) and rf_link=1.
- R10: Jump to immediate (0010110) spends one cycle in state 14 with pc_sel=2 and pc_wr=1. Its linking form (0010111) passes through state 13 first.
- R11: Every path ends in state 15, which drives no enables. With irq=1 and ie_flag=1, state 15 goes to state 16 (ira_wr=1, ie_clr=1) and then to state 17 (pc_sel=3, pc_wr=1) before fetch. isr_addr always equals the vector parameter. Otherwise state 15 goes to fetch.
- R12: A return-from-interrupt (opcode 0011000) spends one cycle in state 7 with pc_sel=4, pc_wr=1 and ie_set=1.
- R13: Any other opcode goes from decode straight to state 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 7 | Opcode field from the instruction register |
| ext | input | 1 | Extension bit: a second instruction word follows |
| br_taken | input | 1 | Branch condition result, used by the datapath |
| irq | input | 1 | Interrupt request |
| ie_flag | input | 1 | Interrupt-enable bit from the status register |
| iord | output | 1 | Memory address source: 0 PC, 1 ALU result |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| imm_wr | output | 1 | Immediate register load |
| rf_wr | output | 1 | Register-file write |
| rf_src | output | 2 | Write data: 0 ALU, 1 memory, 2 PC |
| rf_link | output | 1 | Force write destination to the link register |
| pc_wr | output | 1 | PC load |
| pc_cond | output | 1 | Qualify the PC load with br_taken |
| pc_sel | output | 3 | PC source: 0 ALU, 1 register, 2 immediate, 3 vector, 4 saved |
| alu_a | output | 2 | ALU operand A select |
| alu_b | output | 2 | ALU operand B select |
| alu_op | output | 2 | ALU operation |
| ira_wr | output | 1 | Load the interrupt return address register |
| ie_set | output | 1 | Set the interrupt-enable flag |
| ie_clr | output | 1 | Clear the interrupt-enable flag |
| state_o | output | 5 | Current state code |
| isr_addr | output | 16 | Service routine address |

## Verification
The assertions assume that opcode and ext come from the instruction register and therefore hold steady from decode until the end of an instruction. They also assume that irq and ie_flag only matter when the check-interrupt state samples them. The bench keeps to this by changing all of these inputs only at the fetch boundary. It covers each path with ext at 0 and at 1, and it varies br_taken, irq and ie_flag across instructions so that interrupt entry is both taken and refused.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int OPW = 7;
  localparam int STW = 5;

  typedef enum logic [STW-1:0] {
    ST_FETCH   = 5'd0,
    ST_DECODE  = 5'd1,
    ST_EXEC    = 5'd2,
    ST_ADDR    = 5'd3,
    ST_IMM     = 5'd4,
    ST_MWRITE  = 5'd5,
    ST_WB_MEM  = 5'd6,
    ST_RETI    = 5'd7,
    ST_WB_ALU  = 5'd8,
    ST_MREAD   = 5'd9,
    ST_CMP     = 5'd10,
    ST_BRANCH  = 5'd11,
    ST_JREG    = 5'd12,
    ST_LINK    = 5'd13,
    ST_JIMM    = 5'd14,
    ST_CHKINT  = 5'd15,
    ST_INTSAVE = 5'd16,
    ST_INTJUMP = 5'd17
  } seq_state_e;

  typedef enum logic [3:0] {
    CL_ALU, CL_LOAD, CL_STORE, CL_CMP, CL_JREG, CL_JREGL,
    CL_JIMM, CL_JIMML, CL_BRANCH, CL_RETI, CL_NOP
  } op_class_e;

  localparam logic [OPW-1:0] OPC_LOAD  = 7'b0010000;
  localparam logic [OPW-1:0] OPC_STORE = 7'b0010001;
  localparam logic [OPW-1:0] OPC_CMP   = 7'b0010010;
  localparam logic [OPW-1:0] OPC_JREG  = 7'b0010100;
  localparam logic [OPW-1:0] OPC_JREGL = 7'b0010101;
  localparam logic [OPW-1:0] OPC_JIMM  = 7'b0010110;
  localparam logic [OPW-1:0] OPC_JIMML = 7'b0010111;
  localparam logic [OPW-1:0] OPC_RETI  = 7'b0011000;

  localparam logic [1:0] AOP_OFF = 2'd0;
  localparam logic [1:0] AOP_ADD = 2'd1;
  localparam logic [1:0] AOP_SUB = 2'd2;
  localparam logic [1:0] AOP_FN  = 2'd3;

  localparam logic [2:0] PCS_ALU = 3'd0;
  localparam logic [2:0] PCS_REG = 3'd1;
  localparam logic [2:0] PCS_IMM = 3'd2;
  localparam logic [2:0] PCS_VEC = 3'd3;
  localparam logic [2:0] PCS_IRA = 3'd4;

  localparam logic [1:0] RFS_ALU = 2'd0;
  localparam logic [1:0] RFS_MEM = 2'd1;
  localparam logic [1:0] RFS_PC  = 2'd2;

  typedef struct packed {
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       imm_wr;
    logic       rf_wr;
    logic [1:0] rf_src;
    logic       rf_link;
    logic       pc_wr;
    logic       pc_cond;
    logic [2:0] pc_sel;
    logic [1:0] alu_a;
    logic [1:0] alu_b;
    logic [1:0] alu_op;
    logic       ira_wr;
    logic       ie_set;
    logic       ie_clr;
  } ctl_vec_t;

endpackage

// File: rtl/ctl_opclass.sv
module ctl_opclass
  import ctl_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output op_class_e      cls,
  output logic           imm_capable
);

  always_comb begin
    cls = CL_NOP;
    if (opcode[OPW-1 -: 3] == 3'b000)      cls = CL_ALU;
    else if (opcode[OPW-1 -: 3] == 3'b111) cls = CL_BRANCH;
    else begin
      case (opcode)
        OPC_LOAD:  cls = CL_LOAD;
        OPC_STORE: cls = CL_STORE;
        OPC_CMP:   cls = CL_CMP;
        OPC_JREG:  cls = CL_JREG;
        OPC_JREGL: cls = CL_JREGL;
        OPC_JIMM:  cls = CL_JIMM;
        OPC_JIMML: cls = CL_JIMML;
        OPC_RETI:  cls = CL_RETI;
        default:   cls = CL_NOP;
      endcase
    end
  end

  always_comb begin
    case (cls)
      CL_ALU, CL_LOAD, CL_STORE, CL_CMP, CL_JIMM, CL_JIMML: imm_capable = 1'b1;
      default: imm_capable = 1'b0;
    endcase
  end

endmodule

// File: rtl/ctl_next.sv
module ctl_next
  import ctl_pkg::*;
(
  input  logic       clk,
  input  logic       run_n,
  input  op_class_e  cls,
  input  logic       imm_capable,
  input  logic       ext,
  input  logic       irq,
  input  logic       ie_flag,
  output seq_state_e state
);

  seq_state_e state_nx;

  function automatic seq_state_e dispatch(input op_class_e c);
    case (c)
      CL_ALU:             dispatch = ST_EXEC;
      CL_LOAD, CL_STORE:  dispatch = ST_ADDR;
      CL_CMP:             dispatch = ST_CMP;
      CL_JREG:            dispatch = ST_JREG;
      CL_JREGL, CL_JIMML: dispatch = ST_LINK;
      CL_JIMM:            dispatch = ST_JIMM;
      CL_BRANCH:          dispatch = ST_BRANCH;
      CL_RETI:            dispatch = ST_RETI;
      default:            dispatch = ST_CHKINT;
    endcase
  endfunction

  always_comb begin
    state_nx = state;
    case (state)
      ST_FETCH:   state_nx = ST_DECODE;
      ST_DECODE:  state_nx = (ext && imm_capable) ? ST_IMM : dispatch(cls);
      ST_IMM:     state_nx = dispatch(cls);
      ST_EXEC:    state_nx = ST_WB_ALU;
      ST_ADDR:    state_nx = (cls == CL_STORE) ? ST_MWRITE : ST_MREAD;
      ST_MREAD:   state_nx = ST_WB_MEM;
      ST_LINK:    state_nx = (cls == CL_JREGL) ? ST_JREG : ST_JIMM;
      ST_WB_ALU, ST_WB_MEM, ST_MWRITE, ST_CMP, ST_BRANCH,
      ST_JREG, ST_JIMM, ST_RETI:
                  state_nx = ST_CHKINT;
      ST_CHKINT:  state_nx = (irq && ie_flag) ? ST_INTSAVE : ST_FETCH;
      ST_INTSAVE: state_nx = ST_INTJUMP;
      ST_INTJUMP: state_nx = ST_FETCH;
      default:    state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) state <= ST_FETCH;
    else        state <= state_nx;
  end

  p_fetch_decode_r2: assert property (@(posedge clk) disable iff (!run_n)
    state == ST_FETCH |=> state == ST_DECODE);
  p_imm_origin_r3: assert property (@(posedge clk) disable iff (!run_n)
    state == ST_IMM |-> ($past(state) == ST_DECODE));
  p_load_wb_r5: assert property (@(posedge clk) disable iff (!run_n)
    state == ST_MREAD |=> state == ST_WB_MEM);
  p_int_entry_r11: assert property (@(posedge clk) disable iff (!run_n)
    state == ST_INTSAVE |=> state == ST_INTJUMP);
  p_int_refused_r11: assert property (@(posedge clk) disable iff (!run_n)
    (state == ST_CHKINT && !(irq && ie_flag)) |=> state == ST_FETCH);
  p_undef_skip_r13: assert property (@(posedge clk) disable iff (!run_n)
    (state == ST_DECODE && cls == CL_NOP) |=> state == ST_CHKINT);

endmodule

// File: rtl/ctl_drive.sv
module ctl_drive
  import ctl_pkg::*;
(
  input  logic       clk,
  input  logic       run_n,
  input  seq_state_e state,
  input  logic       ext,
  output ctl_vec_t   ctl
);

  ctl_vec_t raw;

  always_comb begin
    raw = '0;
    case (state)
      ST_FETCH, ST_IMM: begin
        raw.mem_rd = 1'b1;
        raw.ir_wr  = (state == ST_FETCH);
        raw.imm_wr = (state == ST_IMM);
        raw.alu_a  = 2'd2;
        raw.alu_b  = 2'd2;
        raw.alu_op = AOP_ADD;
        raw.pc_sel = PCS_ALU;
        raw.pc_wr  = 1'b1;
      end
      ST_EXEC: begin
        raw.alu_b  = ext ? 2'd1 : 2'd0;
        raw.alu_op = AOP_FN;
      end
      ST_WB_ALU: begin
        raw.rf_wr  = 1'b1;
        raw.rf_src = RFS_ALU;
      end
      ST_ADDR: begin
        raw.alu_a  = 2'd1;
        raw.alu_b  = 2'd1;
        raw.alu_op = AOP_ADD;
      end
      ST_MREAD: begin
        raw.iord   = 1'b1;
        raw.mem_rd = 1'b1;
      end
      ST_WB_MEM: begin
        raw.rf_wr  = 1'b1;
        raw.rf_src = RFS_MEM;
      end
      ST_MWRITE: begin
        raw.iord   = 1'b1;
        raw.mem_wr = 1'b1;
      end
      ST_CMP:    raw.alu_op = AOP_SUB;
      ST_BRANCH: begin
        raw.alu_a   = 2'd2;
        raw.alu_b   = 2'd3;
        raw.alu_op  = AOP_ADD;
        raw.pc_cond = 1'b1;
        raw.pc_wr   = 1'b1;
      end
      ST_LINK: begin
        raw.rf_wr   = 1'b1;
        raw.rf_src  = RFS_PC;
        raw.rf_link = 1'b1;
      end
      ST_JREG: begin
        raw.pc_sel = PCS_REG;
        raw.pc_wr  = 1'b1;
      end
      ST_JIMM: begin
        raw.pc_sel = PCS_IMM;
        raw.pc_wr  = 1'b1;
      end
      ST_RETI: begin
        raw.pc_sel = PCS_IRA;
        raw.pc_wr  = 1'b1;
        raw.ie_set = 1'b1;
      end
      ST_INTSAVE: begin
        raw.ira_wr = 1'b1;
        raw.ie_clr = 1'b1;
      end
      ST_INTJUMP: begin
        raw.pc_sel = PCS_VEC;
        raw.pc_wr  = 1'b1;
      end
      default: raw = '0;
    endcase
  end

  assign ctl = run_n ? raw : '0;

  p_mem_excl_r6: assert property (@(posedge clk) disable iff (!run_n)
    !(ctl.mem_rd && ctl.mem_wr));
  p_ie_excl_r12: assert property (@(posedge clk) disable iff (!run_n)
    !(ctl.ie_set && ctl.ie_clr));
  p_link_pcsrc_r9: assert property (@(posedge clk) disable iff (!run_n)
    ctl.rf_link |-> (ctl.rf_wr && !ctl.pc_wr));
  p_vec_after_save_r11: assert property (@(posedge clk) disable iff (!run_n)
    ctl.ira_wr |=> (ctl.pc_wr && ctl.pc_sel == PCS_VEC));

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_pkg::*;
#(
  parameter logic [15:0] ISR_VECTOR  = 16'h0040,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  opcode,
  input  logic        ext,
  input  logic        br_taken,
  input  logic        irq,
  input  logic        ie_flag,
  output logic        iord,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        ir_wr,
  output logic        imm_wr,
  output logic        rf_wr,
  output logic [1:0]  rf_src,
  output logic        rf_link,
  output logic        pc_wr,
  output logic        pc_cond,
  output logic [2:0]  pc_sel,
  output logic [1:0]  alu_a,
  output logic [1:0]  alu_b,
  output logic [1:0]  alu_op,
  output logic        ira_wr,
  output logic        ie_set,
  output logic        ie_clr,
  output logic [4:0]  state_o,
  output logic [15:0] isr_addr
);

  logic [SYNC_STAGES-1:0] rsync;
  logic                   run_n;
  op_class_e              cls;
  logic                   imm_capable;
  seq_state_e             state;
  ctl_vec_t               ctl;
  logic                   unused_br;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync[g] <= 1'b0;
        else if (g == 0) rsync[g] <= 1'b1;
        else rsync[g] <= rsync[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign run_n     = rsync[SYNC_STAGES-1];
  assign unused_br = br_taken;

  ctl_opclass u_cls (
    .opcode      (opcode),
    .cls         (cls),
    .imm_capable (imm_capable)
  );

  ctl_next u_next (
    .clk         (clk),
    .run_n       (run_n),
    .cls         (cls),
    .imm_capable (imm_capable),
    .ext         (ext),
    .irq         (irq),
    .ie_flag     (ie_flag),
    .state       (state)
  );

  ctl_drive u_drive (
    .clk   (clk),
    .run_n (run_n),
    .state (state),
    .ext   (ext),
    .ctl   (ctl)
  );

  assign iord     = ctl.iord;
  assign mem_rd   = ctl.mem_rd;
  assign mem_wr   = ctl.mem_wr;
  assign ir_wr    = ctl.ir_wr;
  assign imm_wr   = ctl.imm_wr;
  assign rf_wr    = ctl.rf_wr;
  assign rf_src   = ctl.rf_src;
  assign rf_link  = ctl.rf_link;
  assign pc_wr    = ctl.pc_wr;
  assign pc_cond  = ctl.pc_cond;
  assign pc_sel   = ctl.pc_sel;
  assign alu_a    = ctl.alu_a;
  assign alu_b    = ctl.alu_b;
  assign alu_op   = ctl.alu_op;
  assign ira_wr   = ctl.ira_wr;
  assign ie_set   = ctl.ie_set;
  assign ie_clr   = ctl.ie_clr;
  assign state_o  = state;
  assign isr_addr = ISR_VECTOR;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !run_n |-> !(pc_wr || rf_wr || mem_wr || ir_wr || imm_wr || ira_wr));

endmodule

// File: tb/tb_ctl_sequencer.sv
module tb_ctl_sequencer;

  logic clk = 1'b0;
  logic rst_n;
  logic [6:0] opcode;
  logic ext, br_taken, irq, ie_flag;
  logic iord, mem_rd, mem_wr, ir_wr, imm_wr, rf_wr, rf_link, pc_wr, pc_cond;
  logic ira_wr, ie_set, ie_clr;
  logic [1:0] rf_src, alu_a, alu_b, alu_op;
  logic [2:0] pc_sel;
  logic [4:0] state_o;
  logic [15:0] isr_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int m_state  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ctl_sequencer dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .ext(ext), .br_taken(br_taken),
    .irq(irq), .ie_flag(ie_flag), .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_wr(ir_wr), .imm_wr(imm_wr), .rf_wr(rf_wr), .rf_src(rf_src),
    .rf_link(rf_link), .pc_wr(pc_wr), .pc_cond(pc_cond), .pc_sel(pc_sel),
    .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op), .ira_wr(ira_wr),
    .ie_set(ie_set), .ie_clr(ie_clr), .state_o(state_o), .isr_addr(isr_addr)
  );

  // Expected-control layout (23 bits), most significant first:
  // iord mem_rd mem_wr ir_wr imm_wr rf_wr rf_src[2] rf_link pc_wr pc_cond
  // pc_sel[3] alu_a[2] alu_b[2] alu_op[2] ira_wr ie_set ie_clr
  function automatic logic [22:0] pack(input int io, mr, mw, ir, im, rw, rs, lk,
                                       pw, pc, ps, aa, ab, ao, ia, es, ec);
    logic [22:0] v;
    v = {io[0], mr[0], mw[0], ir[0], im[0], rw[0], rs[1:0], lk[0], pw[0], pc[0],
         ps[2:0], aa[1:0], ab[1:0], ao[1:0], ia[0], es[0], ec[0]};
    return v;
  endfunction

  function automatic logic [22:0] model_ctl(input int s, input logic e);
    case (s)
      0:  return pack(0,1,0,1,0,0,0,0,1,0,0,2,2,1,0,0,0);
      4:  return pack(0,1,0,0,1,0,0,0,1,0,0,2,2,1,0,0,0);
      2:  return pack(0,0,0,0,0,0,0,0,0,0,0,0,e ? 1 : 0,3,0,0,0);
      8:  return pack(0,0,0,0,0,1,0,0,0,0,0,0,0,0,0,0,0);
      3:  return pack(0,0,0,0,0,0,0,0,0,0,0,1,1,1,0,0,0);
      9:  return pack(1,1,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0);
      6:  return pack(0,0,0,0,0,1,1,0,0,0,0,0,0,0,0,0,0);
      5:  return pack(1,0,1,0,0,0,0,0,0,0,0,0,0,0,0,0,0);
      10: return pack(0,0,0,0,0,0,0,0,0,0,0,0,0,2,0,0,0);
      11: return pack(0,0,0,0,0,0,0,0,1,1,0,2,3,1,0,0,0);
      13: return pack(0,0,0,0,0,1,2,1,0,0,0,0,0,0,0,0,0);
      12: return pack(0,0,0,0,0,0,0,0,1,0,1,0,0,0,0,0,0);
      14: return pack(0,0,0,0,0,0,0,0,1,0,2,0,0,0,0,0,0);
      7:  return pack(0,0,0,0,0,0,0,0,1,0,4,0,0,0,0,1,0);
      16: return pack(0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,0,1);
      17: return pack(0,0,0,0,0,0,0,0,1,0,3,0,0,0,0,0,0);
      default: return '0;
    endcase
  endfunction

  // Instruction kind: 1 alu 2 load 3 store 4 cmp 5 jreg 6 jregl 7 jimm
  // 8 jimml 9 branch 10 reti 0 undefined
  function automatic int kind_of(input logic [6:0] op);
    if (op[6:4] == 3'b000) return 1;
    if (op[6:4] == 3'b111) return 9;
    if (op == 7'h10) return 2;
    if (op == 7'h11) return 3;
    if (op == 7'h12) return 4;
    if (op == 7'h14) return 5;
    if (op == 7'h15) return 6;
    if (op == 7'h16) return 7;
    if (op == 7'h17) return 8;
    if (op == 7'h18) return 10;
    return 0;
  endfunction

  function automatic int first_exec(input int k);
    int tbl[11] = '{15, 2, 3, 3, 10, 12, 13, 14, 13, 11, 7};
    return tbl[k];
  endfunction

  function automatic int model_next(input int s, input logic [6:0] op,
                                    input logic e, input logic rq, input logic ie);
    int k;
    k = kind_of(op);
    case (s)
      0: return 1;
      1: return (e && (k inside {1,2,3,4,7,8})) ? 4 : first_exec(k);
      4: return first_exec(k);
      2: return 8;
      3: return (k == 3) ? 5 : 9;
      9: return 6;
      13: return (k == 6) ? 12 : 14;
      15: return (rq && ie) ? 16 : 0;
      16: return 17;
      17: return 0;
      default: return 15;
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [22:0] got, exp;
    got = {iord, mem_rd, mem_wr, ir_wr, imm_wr, rf_wr, rf_src, rf_link, pc_wr,
           pc_cond, pc_sel, alu_a, alu_b, alu_op, ira_wr, ie_set, ie_clr};
    exp = model_ctl(m_state, ext);
    n_checks++;
    if (state_o !== m_state[4:0]) begin
      n_fail++;
      $display("FAIL %s state: actual %0d expected %0d", tag, state_o, m_state);
    end
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s controls in state %0d: actual %h expected %h",
               tag, m_state, got, exp);
    end
  endtask

  task automatic run_instr(input logic [6:0] op, input logic e, input logic c,
                           input logic rq, input logic ie, input string tag);
    int ns;
    int guard;
    opcode = op; ext = e; br_taken = c; irq = rq; ie_flag = ie;
    guard = 0;
    do begin
      #1;
      check_now(tag);
      ns = model_next(m_state, op, e, rq, ie);
      @(posedge clk);
      @(negedge clk);
      m_state = ns;
      guard++;
    end while (m_state != 0 && guard < 16);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; opcode = '0; ext = 0; br_taken = 0; irq = 0; ie_flag = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs while held in reset
    m_state = 0;
    #1;
    n_checks++;
    if ({ir_wr, pc_wr, mem_rd, alu_op} !== '0 || state_o !== 5'd0) begin
      n_fail++;
      $display("FAIL R1 in reset: actual %b%b%b%b st %0d expected 0", ir_wr, pc_wr,
               mem_rd, alu_op, state_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    n_checks++;
    if ({ir_wr, pc_wr, mem_rd, rf_wr, mem_wr} !== '0 || state_o !== 5'd0) begin
      n_fail++;
      $display("FAIL R1 after release: actual %b%b%b st %0d expected 0", ir_wr,
               pc_wr, mem_rd, state_o);
    end
    @(posedge clk); @(negedge clk);
    // R11: vector port
    n_checks++;
    if (isr_addr !== 16'h0040) begin
      n_fail++;
      $display("FAIL R11 vector: actual %h expected 0040", isr_addr);
    end
    run_instr(7'b0000011, 0, 0, 0, 0, "R4 R2 alu ext0");
    run_instr(7'b0000101, 1, 0, 0, 0, "R4 R3 alu ext1");
    run_instr(7'b0010000, 0, 0, 0, 0, "R5 load");
    run_instr(7'b0010000, 1, 0, 0, 0, "R5 R3 load ext1");
    run_instr(7'b0010001, 1, 0, 0, 0, "R6 store");
    run_instr(7'b0010010, 0, 0, 0, 0, "R7 compare");
    run_instr(7'b1110101, 1, 1, 0, 0, "R8 branch taken ext ignored");
    run_instr(7'b1110000, 0, 0, 0, 0, "R8 branch not taken");
    run_instr(7'b0010100, 1, 0, 0, 0, "R9 jreg ext ignored");
    run_instr(7'b0010101, 0, 0, 0, 0, "R9 jreg link");
    run_instr(7'b0010110, 1, 0, 0, 0, "R10 jimm");
    run_instr(7'b0010111, 1, 0, 0, 0, "R10 jimm link");
    run_instr(7'b0000001, 0, 0, 1, 1, "R11 irq taken");
    run_instr(7'b0011000, 0, 0, 0, 0, "R12 reti");
    run_instr(7'b0010010, 0, 0, 1, 0, "R11 irq masked");
    run_instr(7'b0010000, 0, 0, 0, 1, "R11 enabled no irq");
    run_instr(7'b0100000, 1, 0, 0, 0, "R13 undefined");
    run_instr(7'b0011111, 0, 0, 1, 1, "R13 R11 undefined then irq");
    run_instr(7'b0010001, 0, 0, 1, 1, "R6 R11 store then irq");
    #1;
    check_now("R2 final fetch");
    finished = 1;
    summary();
    $finish;
  end

endmodule